// File: doc/BRIEF.md
# Color Channel Sampling Sequencer

This block chooses which color channel a shared converter digitises on each conversion of a three-channel imaging front end. It runs on one system clock. A one-cycle tick input marks each conversion instant, and the block answers every tick, one cycle later, with a sample strobe and a 2-bit channel tag. Downstream logic can then sort the samples by color without knowing the operating mode.

In three-channel mode the tag steps through the channels in one of two orders, chosen by a control bit. The order is either red, green, blue or the reverse. The data-sample clock of the pixel is asynchronous to the system clock. It passes through a synchroniser, and each of its rising edges arms a restart, so the next conversion goes back to the first channel of the order. Between restarts the order wraps around.

In single-channel mode the tag stays on the one channel picked by three one-hot select bits. If those bits are not one-hot, the block uses red and raises a configuration-error flag.

Top module: `chan_sampling_seq`

## Requirements
- R1: During and right after synchronous reset, `smp_tag` is 00 (red), `smp_stb` is low and `cfg_err` is low. This holds as long as exactly one select bit is set.
- R2: `smp_stb` is high in the cycle after each cycle in which `conv_tick` is high, and low in every other cycle.
- R3: In three-channel mode with `order_fwd` high, successive conversions are tagged 00 (red), 01 (green), 10 (blue), and the order wraps from blue back to red.
- R4: In three-channel mode with `order_fwd` low, successive conversions are tagged 10 (blue), 01 (green), 00 (red), and the order wraps from red back to blue.
- R5: Suppose `pix_clk_in` rises before clock edge k (with the default two synchroniser stages). A conversion ticked at edge k+1 still follows the running order. The first conversion ticked at edge k+2 or later takes the first channel of the order: red for forward order, blue for reverse order.
- R6: Each rising edge of `pix_clk_in` causes exactly one restart. While the input stays high, later conversions keep advancing through the order.
- R7: In single-channel mode every conversion takes the channel of the set select bit: `solo_r` gives 00, `solo_g` gives 01 and `solo_b` gives 10. `order_fwd` and `pix_clk_in` have no effect.
- R8: When zero, two or three select bits are set, single-channel conversions are tagged 00 (red). `cfg_err` is high one cycle after that select pattern appears, in either mode, and low one cycle after exactly one bit is set again.
- R9: After reset, the first conversion in three-channel mode takes the first channel of the order, even if no pixel edge has been seen.
- R10: `smp_tag` changes only in cycles where `smp_stb` is high, and it never shows the code 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_tick | input | 1 | One-cycle marker of a conversion instant |
| pix_clk_in | input | 1 | Asynchronous data-sample clock of the pixel; a rising edge arms a restart |
| three_ch | input | 1 | 1 = three-channel mode, 0 = single-channel mode |
| order_fwd | input | 1 | 1 = red-green-blue order, 0 = blue-green-red order |
| solo_r | input | 1 | Single-channel select, red |
| solo_g | input | 1 | Single-channel select, green |
| solo_b | input | 1 | Single-channel select, blue |
| smp_tag | output | 2 | Channel of the latest conversion (00 red, 01 green, 10 blue) |
| smp_stb | output | 1 | Strobe, high for one cycle per conversion |
| cfg_err | output | 1 | Single-channel select bits are not one-hot |

## Verification
The bench targets the exact cycle at which a synchronised pixel edge takes effect. A design with one stage too few or too many in the path would restart the tick at edge k+1 or miss the one at k+2. It holds the pixel input high over many conversions, which a level-triggered restart would fail by pinning the tag to the first channel. The bench also sweeps all eight select patterns in both orders. This catches wrong encodings, a fallback to something other than red, an error flag that ignores the zero-bit or three-bit cases, and a single-channel mode that still steps or restarts.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;

  localparam int TAG_W = 2;
  localparam int NUM_CH = 3;

  typedef enum logic [TAG_W-1:0] {
    CH_RED   = 2'b00,
    CH_GREEN = 2'b01,
    CH_BLUE  = 2'b10
  } chan_e;

  // Channel at the head of the sequence for a given order.
  function automatic chan_e head_of(input logic fwd);
    return fwd ? CH_RED : CH_BLUE;
  endfunction

endpackage

// File: rtl/cs_pulse_sync.sv
module cs_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);

  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise_o = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/cs_sel_decode.sv
module cs_sel_decode
  import chan_seq_pkg::*;
(
  input  logic  sel_r,
  input  logic  sel_g,
  input  logic  sel_b,
  output chan_e fixed_o,
  output logic  bad_o
);

  logic [NUM_CH-1:0] bits;
  assign bits = {sel_b, sel_g, sel_r};

  always_comb begin
    bad_o   = 1'b0;
    fixed_o = CH_RED;
    unique case (bits)
      3'b001:  fixed_o = CH_RED;
      3'b010:  fixed_o = CH_GREEN;
      3'b100:  fixed_o = CH_BLUE;
      default: begin
        fixed_o = CH_RED;
        bad_o   = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/cs_order_step.sv
module cs_order_step
  import chan_seq_pkg::*;
(
  input  chan_e cur_i,
  input  logic  fwd_i,
  output chan_e nxt_o
);

  always_comb begin
    nxt_o = head_of(fwd_i);
    if (fwd_i) begin
      case (cur_i)
        CH_RED:   nxt_o = CH_GREEN;
        CH_GREEN: nxt_o = CH_BLUE;
        default:  nxt_o = CH_RED;
      endcase
    end else begin
      case (cur_i)
        CH_BLUE:  nxt_o = CH_GREEN;
        CH_GREEN: nxt_o = CH_RED;
        default:  nxt_o = CH_BLUE;
      endcase
    end
  end

endmodule

// File: rtl/chan_sampling_seq.sv
module chan_sampling_seq
  import chan_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_tick,
  input  logic             pix_clk_in,
  input  logic             three_ch,
  input  logic             order_fwd,
  input  logic             solo_r,
  input  logic             solo_g,
  input  logic             solo_b,
  output logic [TAG_W-1:0] smp_tag,
  output logic             smp_stb,
  output logic             cfg_err
);

  logic  pix_rise;
  logic  pend_q;
  logic  restart_now;
  chan_e tag_q;
  chan_e step_nxt;
  chan_e solo_ch;
  logic  solo_bad;
  logic  stb_q;
  logic  err_q;

  cs_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pix_clk_in),
    .rise_o   (pix_rise)
  );

  cs_sel_decode u_dec (
    .sel_r   (solo_r),
    .sel_g   (solo_g),
    .sel_b   (solo_b),
    .fixed_o (solo_ch),
    .bad_o   (solo_bad)
  );

  cs_order_step u_step (
    .cur_i (tag_q),
    .fwd_i (order_fwd),
    .nxt_o (step_nxt)
  );

  // A pending restart is consumed by the next conversion tick.
  assign restart_now = pix_rise | pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b1;
      tag_q  <= CH_RED;
      stb_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      stb_q <= conv_tick;
      err_q <= solo_bad;
      if (conv_tick) begin
        pend_q <= 1'b0;
        if (!three_ch)        tag_q <= solo_ch;
        else if (restart_now) tag_q <= head_of(order_fwd);
        else                  tag_q <= step_nxt;
      end else begin
        pend_q <= restart_now;
      end
    end
  end

  assign smp_tag = tag_q;
  assign smp_stb = stb_q;
  assign cfg_err = err_q;

endmodule

// File: rtl/cs_seq_checker.sv
module cs_seq_checker (
  input logic       clk,
  input logic       rst,
  input logic       conv_tick,
  input logic       three_ch,
  input logic       order_fwd,
  input logic       solo_r,
  input logic       solo_g,
  input logic       solo_b,
  input logic [1:0] smp_tag,
  input logic       smp_stb,
  input logic       cfg_err,
  input logic       restart_now
);

  p_stb_follows_r2: assert property (@(posedge clk) disable iff (rst)
    conv_tick |=> smp_stb);

  p_stb_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !conv_tick |=> !smp_stb);

  p_fwd_step_r3: assert property (@(posedge clk) disable iff (rst)
    (conv_tick && three_ch && order_fwd && !restart_now && smp_tag == 2'b00)
      |=> smp_tag == 2'b01);

  p_rev_step_r4: assert property (@(posedge clk) disable iff (rst)
    (conv_tick && three_ch && !order_fwd && !restart_now && smp_tag == 2'b10)
      |=> smp_tag == 2'b01);

  p_restart_head_r5: assert property (@(posedge clk) disable iff (rst)
    (conv_tick && three_ch && restart_now)
      |=> smp_tag == ($past(order_fwd) ? 2'b00 : 2'b10));

  p_solo_green_r7: assert property (@(posedge clk) disable iff (rst)
    (conv_tick && !three_ch && {solo_b, solo_g, solo_r} == 3'b010)
      |=> smp_tag == 2'b01);

  p_solo_blue_r7: assert property (@(posedge clk) disable iff (rst)
    (conv_tick && !three_ch && {solo_b, solo_g, solo_r} == 3'b100)
      |=> smp_tag == 2'b10);

  p_bad_sel_flag_r8: assert property (@(posedge clk) disable iff (rst)
    ($countones({solo_b, solo_g, solo_r}) != 1) |=> cfg_err);

  p_bad_sel_red_r8: assert property (@(posedge clk) disable iff (rst)
    (conv_tick && !three_ch && $countones({solo_b, solo_g, solo_r}) != 1)
      |=> smp_tag == 2'b00);

  p_tag_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |-> $stable(smp_tag));

  p_tag_legal_r10: assert property (@(posedge clk) disable iff (rst)
    smp_tag != 2'b11);

endmodule

bind chan_sampling_seq cs_seq_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .conv_tick   (conv_tick),
  .three_ch    (three_ch),
  .order_fwd   (order_fwd),
  .solo_r      (solo_r),
  .solo_g      (solo_g),
  .solo_b      (solo_b),
  .smp_tag     (smp_tag),
  .smp_stb     (smp_stb),
  .cfg_err     (cfg_err),
  .restart_now (restart_now)
);

// File: tb/test_chan_sampling_seq.sv
`timescale 1ns/1ps
module test_chan_sampling_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       conv_tick = 1'b0;
  logic       pix_clk_in = 1'b0;
  logic       three_ch = 1'b1;
  logic       order_fwd = 1'b1;
  logic       solo_r = 1'b1;
  logic       solo_g = 1'b0;
  logic       solo_b = 1'b0;
  logic [1:0] smp_tag;
  logic       smp_stb;
  logic       cfg_err;

  int vectors = 0;
  int fails = 0;
  int idx = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chan_sampling_seq i_chan_sampling_seq (
    .clk(clk), .rst(rst), .conv_tick(conv_tick), .pix_clk_in(pix_clk_in),
    .three_ch(three_ch), .order_fwd(order_fwd),
    .solo_r(solo_r), .solo_g(solo_g), .solo_b(solo_b),
    .smp_tag(smp_tag), .smp_stb(smp_stb), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Channel code at position i of the order: forward 0,1,2; reverse 2,1,0.
  function automatic int chan_at(input bit fwd, input int i);
    return fwd ? i : 2 - i;
  endfunction

  // One conversion: tick for one cycle, then check strobe and tag.
  task automatic tick_and_check(input string req, input int exp_tag);
    @(negedge clk) conv_tick = 1'b1;
    @(negedge clk) conv_tick = 1'b0;
    check({req, " strobe"}, smp_stb, 1);
    check(req, smp_tag, exp_tag);
    @(negedge clk);
    check("R2 strobe idle", smp_stb, 0);
  endtask

  task automatic pixel_pulse();
    @(negedge clk) pix_clk_in = 1'b1;
    repeat (3) @(negedge clk);
    pix_clk_in = 1'b0;
    repeat (3) @(negedge clk);
    idx = 0;
  endtask

  task automatic run_order(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      tick_and_check(req, chan_at(order_fwd, idx));
      idx = (idx + 1) % 3;
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 tag in reset", smp_tag, 0);
    check("R1 strobe in reset", smp_stb, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 tag after reset", smp_tag, 0);
    check("R1 strobe after reset", smp_stb, 0);
    check("R1 cfg_err after reset", cfg_err, 0);

    // R9 first conversion after reset, then R3 forward order with wrap
    idx = 0;
    run_order("R9 first after reset", 1);
    run_order("R3 forward order", 6);

    pixel_pulse();
    run_order("R5 restart forward", 4);

    // R4 reverse order with wrap
    order_fwd = 1'b0;
    pixel_pulse();
    run_order("R4 reverse order", 7);

    // R5 exact cycle boundary, both orders
    for (int f = 0; f < 2; f++) begin
      order_fwd = f[0];
      pixel_pulse();
      run_order("R5 lead-in", 2);
      @(negedge clk) pix_clk_in = 1'b1;          // rises before edge k
      @(negedge clk) conv_tick = 1'b1;           // captured at edge k+1
      @(negedge clk);                            // captured again at k+2
      check("R5 tick at k+1 continues", smp_tag, chan_at(order_fwd, idx));
      @(negedge clk) conv_tick = 1'b0;
      check("R5 tick at k+2 restarts", smp_tag, chan_at(order_fwd, 0));
      idx = 1;
      run_order("R5 after restart", 2);
      pix_clk_in = 1'b0;
      repeat (3) @(negedge clk);
    end

    // R6 pixel input held high: exactly one restart
    order_fwd = 1'b1;
    run_order("R6 lead-in", 1);
    @(negedge clk) pix_clk_in = 1'b1;
    repeat (3) @(negedge clk);
    idx = 0;
    run_order("R6 held high", 8);
    pix_clk_in = 1'b0;
    repeat (3) @(negedge clk);

    // R7 / R8 single-channel sweep over all select patterns and orders
    three_ch = 1'b0;
    for (int s = 0; s < 8; s++) begin
      for (int f = 0; f < 2; f++) begin
        int ones;
        int exp_ch;
        {solo_b, solo_g, solo_r} = s[2:0];
        order_fwd = f[0];
        ones = s[0] + s[1] + s[2];
        exp_ch = (s == 2) ? 1 : (s == 4) ? 2 : 0;
        @(negedge clk);
        check(ones == 1 ? "R8 cfg_err clear" : "R8 cfg_err set",
              cfg_err, ones == 1 ? 0 : 1);
        tick_and_check(ones == 1 ? "R7 single channel" : "R8 fallback red", exp_ch);
        pix_clk_in = 1'b1;
        repeat (3) @(negedge clk);
        tick_and_check("R7 pixel edge ignored", exp_ch);
        pix_clk_in = 1'b0;
        tick_and_check("R7 fixed channel", exp_ch);
      end
    end

    // R8 flag also in three-channel mode
    three_ch = 1'b1;
    {solo_b, solo_g, solo_r} = 3'b011;
    @(negedge clk) @(negedge clk);
    check("R8 cfg_err in three-channel mode", cfg_err, 1);
    {solo_b, solo_g, solo_r} = 3'b100;
    @(negedge clk) @(negedge clk);
    check("R8 cfg_err cleared", cfg_err, 0);
    order_fwd = 1'b0;
    pixel_pulse();
    run_order("R4 after mode return", 4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule